// File: doc/BRIEF.md
# Dual-Port Mailbox Memory with Contention Arbiter

This block is a shared word store reached through two independent ports, A and B. Each port has its own select, write strobe, output strobe, address and data lines. Two processors can use it to pass messages: each one sees an ordinary RAM. All inputs are sampled on one clock. Reads are combinational from the array. Writes take effect at the rising edge.

The central part is the contention logic. A clash exists when both ports are selected on the same address. The port that reached that address first owns it. The other port gets its active-low wait flag pulled low, and its writes are dropped until the addresses differ again. Its reads still return the stored word. "First" means the port whose select and address were already present on the previous clock. This covers a port that set its address earlier and a port that asserted its select earlier. When neither port was there before, port A takes the tie. The decision is stored and held for as long as the clash lasts.

The wait flag is the only back-pressure at the ports; there is no valid/ready handshake. The back-pressure rule is simple: while a port's wait flag is low, a write it presents is not taken. The processor keeps its request on the lines. When the flag returns high, the request is taken at that edge.

Top module: `mbox_dual_port`

## Requirements
- R1: A port whose select input is high performs neither read nor write, whatever its strobes are. Its read-enable output is 0 and its read data is all zeros.
- R2: With select low and write strobe low, a port that is not waiting stores its write data at its address on the rising edge.
- R3: With select low, write strobe high and output strobe low, the port's read-enable is 1 and its read data equals the stored word in the same cycle. With the output strobe high instead, read-enable is 0 and the read data is zero.
- R4: Both wait flags are high after reset, and whenever the two ports are not both selected on equal addresses.
- R5: When a clash begins because one port changed its address onto the other's, the port whose select and address were unchanged from the previous cycle keeps its wait flag high. The other port's wait flag goes low in that same cycle.
- R6: When a clash begins because one port asserts its select onto an address that the other selected port already holds, the earlier-selected port wins. The later port's wait flag goes low.
- R7: When both ports arrive at the matching condition in the same cycle, port A wins and only port B's wait flag goes low.
- R8: While a port's wait flag is low, its writes do not change the array, but its reads still return the stored word.
- R9: The winner of a clash stays the winner for every cycle in which the clash continues.
- R10: When the addresses diverge, the waiting port's flag is high in that same cycle, and a write it still presents is stored at that edge.
- R11: When both ports read one address, both receive the stored word. A word written by the winner is returned to the losing port's read from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on rising edge |
| rst_n | input | 1 | Active-low reset of arbitration state |
| pa_cs_n | input | 1 | Port A select, active low |
| pa_we_n | input | 1 | Port A write strobe, active low |
| pa_oe_n | input | 1 | Port A output strobe, active low |
| pa_addr | input | ADDR_W | Port A word address |
| pa_wdata | input | DATA_W | Port A write data |
| pa_rdata | output | DATA_W | Port A read data, zero when not reading |
| pa_rdata_en | output | 1 | Port A read data drive enable |
| pa_wait_n | output | 1 | Port A not-ready flag, active low |
| pb_cs_n | input | 1 | Port B select, active low |
| pb_we_n | input | 1 | Port B write strobe, active low |
| pb_oe_n | input | 1 | Port B output strobe, active low |
| pb_addr | input | ADDR_W | Port B word address |
| pb_wdata | input | DATA_W | Port B write data |
| pb_rdata | output | DATA_W | Port B read data, zero when not reading |
| pb_rdata_en | output | 1 | Port B read data drive enable |
| pb_wait_n | output | 1 | Port B not-ready flag, active low |

## Verification
The bench builds the block with its default widths: an 8-bit address and 8-bit words, which gives a 256-word array. At that size the bench can fill and read back every location through the two ports. It can then run contention at addresses spread across the whole range. Every winner order (address-first, select-first, tie) is crossed with every read/write pairing of the two ports. The array contents are compared against the bench's own model on every cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic {OWN_A = 1'b0, OWN_B = 1'b1} owner_e;

  typedef struct packed {
    logic sel;
    logic wr;
    logic rd;
  } port_op_t;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
  import mbox_pkg::*;
(
  input  logic     cs_n,
  input  logic     we_n,
  input  logic     oe_n,
  output port_op_t op
);
  always_comb begin
    op.sel = ~cs_n;
    op.wr  = ~cs_n & ~we_n;
    op.rd  = ~cs_n & we_n & ~oe_n;
  end
endmodule

// File: rtl/mbox_arbiter.sv
module mbox_arbiter
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              wait_a_n,
  output logic              wait_b_n
);
  logic              sel_a_q, sel_b_q, clash_q;
  logic [ADDR_W-1:0] addr_a_q, addr_b_q;
  owner_e            own_q, own_d;
  logic              clash, settled_a, settled_b;

  assign clash     = sel_a & sel_b & (addr_a == addr_b);
  assign settled_a = sel_a_q & (addr_a_q == addr_a);
  assign settled_b = sel_b_q & (addr_b_q == addr_b);

  always_comb begin
    own_d = OWN_A;
    if (clash) begin
      if (clash_q)                      own_d = own_q;
      else if (settled_b && !settled_a) own_d = OWN_B;
      else                              own_d = OWN_A;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a_q  <= 1'b0;
      sel_b_q  <= 1'b0;
      addr_a_q <= '0;
      addr_b_q <= '0;
      clash_q  <= 1'b0;
      own_q    <= OWN_A;
    end else begin
      sel_a_q  <= sel_a;
      sel_b_q  <= sel_b;
      addr_a_q <= addr_a;
      addr_b_q <= addr_b;
      clash_q  <= clash;
      own_q    <= own_d;
    end
  end

  assign wait_a_n = ~(clash & (own_d == OWN_B));
  assign wait_b_n = ~(clash & (own_d == OWN_A));

  // R4: a low flag only while both ports sit on one address
  a_r4_wait_needs_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_a_n || !wait_b_n) |-> (sel_a && sel_b && addr_a == addr_b));

  // R5: an unchanged port keeps priority over a newcomer
  a_r5_settled_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a && sel_b && addr_a == addr_b && $past(sel_b) && $past(addr_b) == addr_b &&
     !($past(sel_a) && $past(addr_a) == addr_a)) |-> (wait_b_n && !wait_a_n));

  // R7: simultaneous arrival from idle goes to port A
  a_r7_tie_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a && sel_b && addr_a == addr_b && !$past(sel_a) && !$past(sel_b))
      |-> (wait_a_n && !wait_b_n));

  // R9: a waiting port stays waiting while the clash lasts
  a_r9_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_a_n) |=> (!(sel_a && sel_b && addr_a == addr_b) || !wait_a_n));
  a_r9_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_b_n) |=> (!(sel_a && sel_b && addr_a == addr_b) || !wait_b_n));
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PORTS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORTS-1:0]  we,
  input  logic [PORTS-1:0]  re,
  input  logic [ADDR_W-1:0] addr [PORTS],
  input  logic [DATA_W-1:0] wdata [PORTS],
  output logic [DATA_W-1:0] rdata [PORTS]
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (we[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar g = 0; g < PORTS; g++) begin : g_rd
    assign rdata[g] = re[g] ? mem[addr[g]] : '0;
  end

  // R8: arbitration never lets two writers hit one word
  a_r8_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(we[0] && we[1] && addr[0] == addr[1]));
endmodule

// File: rtl/mbox_dual_port.sv
module mbox_dual_port
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pa_cs_n,
  input  logic              pa_we_n,
  input  logic              pa_oe_n,
  input  logic [ADDR_W-1:0] pa_addr,
  input  logic [DATA_W-1:0] pa_wdata,
  output logic [DATA_W-1:0] pa_rdata,
  output logic              pa_rdata_en,
  output logic              pa_wait_n,
  input  logic              pb_cs_n,
  input  logic              pb_we_n,
  input  logic              pb_oe_n,
  input  logic [ADDR_W-1:0] pb_addr,
  input  logic [DATA_W-1:0] pb_wdata,
  output logic [DATA_W-1:0] pb_rdata,
  output logic              pb_rdata_en,
  output logic              pb_wait_n
);
  localparam int PORTS = 2;

  logic [PORTS-1:0]  cs_n_v, we_n_v, oe_n_v, ok_v, we_v, re_v;
  logic [ADDR_W-1:0] addr_v  [PORTS];
  logic [DATA_W-1:0] wdata_v [PORTS];
  logic [DATA_W-1:0] rdata_v [PORTS];
  port_op_t          op_v    [PORTS];

  assign cs_n_v     = {pb_cs_n, pa_cs_n};
  assign we_n_v     = {pb_we_n, pa_we_n};
  assign oe_n_v     = {pb_oe_n, pa_oe_n};
  assign addr_v[0]  = pa_addr;
  assign addr_v[1]  = pb_addr;
  assign wdata_v[0] = pa_wdata;
  assign wdata_v[1] = pb_wdata;

  for (genvar g = 0; g < PORTS; g++) begin : g_port
    mbox_port_decode u_dec (
      .cs_n (cs_n_v[g]),
      .we_n (we_n_v[g]),
      .oe_n (oe_n_v[g]),
      .op   (op_v[g])
    );
    assign we_v[g] = op_v[g].wr & ok_v[g];
    assign re_v[g] = op_v[g].rd;
  end

  mbox_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_a    (op_v[0].sel),
    .sel_b    (op_v[1].sel),
    .addr_a   (pa_addr),
    .addr_b   (pb_addr),
    .wait_a_n (ok_v[0]),
    .wait_b_n (ok_v[1])
  );

  mbox_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORTS(PORTS)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we_v),
    .re    (re_v),
    .addr  (addr_v),
    .wdata (wdata_v),
    .rdata (rdata_v)
  );

  assign pa_rdata    = rdata_v[0];
  assign pb_rdata    = rdata_v[1];
  assign pa_rdata_en = re_v[0];
  assign pb_rdata_en = re_v[1];
  assign pa_wait_n   = ok_v[0];
  assign pb_wait_n   = ok_v[1];

  // R1: a deselected port drives nothing
  a_r1_desel_quiet_a: assert property (@(posedge clk) disable iff (!rst_n)
    pa_cs_n |-> (!pa_rdata_en && pa_rdata == '0));
  a_r1_desel_quiet_b: assert property (@(posedge clk) disable iff (!rst_n)
    pb_cs_n |-> (!pb_rdata_en && pb_rdata == '0));
endmodule

// File: tb/sim_mbox_dual_port.sv
module sim_mbox_dual_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_cs_n = 1'b1, a_we_n = 1'b1, a_oe_n = 1'b1;
  logic       b_cs_n = 1'b1, b_we_n = 1'b1, b_oe_n = 1'b1;
  logic [7:0] a_addr = '0, b_addr = '0, a_wd = '0, b_wd = '0;
  logic [7:0] a_rd, b_rd;
  logic       a_en, b_en, a_wait_n, b_wait_n;

  always #4 clk = ~clk;

  mbox_dual_port u0 (
    .clk(clk), .rst_n(rst_n),
    .pa_cs_n(a_cs_n), .pa_we_n(a_we_n), .pa_oe_n(a_oe_n), .pa_addr(a_addr),
    .pa_wdata(a_wd), .pa_rdata(a_rd), .pa_rdata_en(a_en), .pa_wait_n(a_wait_n),
    .pb_cs_n(b_cs_n), .pb_we_n(b_we_n), .pb_oe_n(b_oe_n), .pb_addr(b_addr),
    .pb_wdata(b_wd), .pb_rdata(b_rd), .pb_rdata_en(b_en), .pb_wait_n(b_wait_n)
  );

  int    checks = 0, errors = 0, cyc = 0;
  string tag = "R4";

  // behavioural reference state
  logic [7:0] ref_mem [256];
  int         arr_a = 0, arr_b = 0;
  bit         psel_a = 0, psel_b = 0, pclash = 0, pown_b = 0;
  logic [7:0] paddr_a = '0, paddr_b = '0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drv_a(input bit sel, input bit wr, input logic [7:0] ad);
    a_cs_n = !sel; a_we_n = !wr; a_oe_n = wr; a_addr = ad;
    a_wd = 8'(cyc * 29 + 17);
  endtask

  task automatic drv_b(input bit sel, input bit wr, input logic [7:0] ad);
    b_cs_n = !sel; b_we_n = !wr; b_oe_n = wr; b_addr = ad;
    b_wd = 8'(cyc * 53 + 91);
  endtask

  // one clock: predict, compare, commit
  task automatic tick();
    bit sa, sb, cl, ob, ewa, ewb, ra, rb;
    int na, nb;
    #1;
    sa = !a_cs_n; sb = !b_cs_n;
    na = (sa && (!psel_a || a_addr != paddr_a)) ? cyc : arr_a;
    nb = (sb && (!psel_b || b_addr != paddr_b)) ? cyc : arr_b;
    cl = sa && sb && (a_addr == b_addr);
    ob = pclash ? pown_b : (nb < na);
    ewa = !(cl && ob);
    ewb = !(cl && !ob);
    ra = sa && a_we_n && !a_oe_n;
    rb = sb && b_we_n && !b_oe_n;
    chk("A wait", 32'(a_wait_n), 32'(ewa));
    chk("B wait", 32'(b_wait_n), 32'(ewb));
    chk("A rd_en", 32'(a_en), 32'(ra));
    chk("B rd_en", 32'(b_en), 32'(rb));
    chk("A rdata", 32'(a_rd), ra ? 32'(ref_mem[a_addr]) : 32'd0);
    chk("B rdata", 32'(b_rd), rb ? 32'(ref_mem[b_addr]) : 32'd0);
    @(posedge clk);
    if (sa && !a_we_n && ewa) ref_mem[a_addr] = a_wd;
    if (sb && !b_we_n && ewb) ref_mem[b_addr] = b_wd;
    arr_a = na; arr_b = nb;
    psel_a = sa; psel_b = sb; paddr_a = a_addr; paddr_b = b_addr;
    pclash = cl; pown_b = cl ? ob : 1'b0;
    cyc++;
    @(negedge clk);
  endtask

  // kind: 0 A first by address, 1 B first by address, 2 tie, 3 A first by select, 4 B first by select
  task automatic contend(input int kind, input bit ma, input bit mb, input logic [7:0] x);
    string first;
    first = (kind == 2) ? "R7" : (kind >= 3) ? "R6" : "R5";
    case (kind)
      0: begin drv_a(1, ma, x); drv_b(1, mb, x + 8'd1); end
      1: begin drv_b(1, mb, x); drv_a(1, ma, x + 8'd1); end
      3: begin drv_a(1, ma, x); drv_b(0, mb, x); end
      4: begin drv_b(1, mb, x); drv_a(0, ma, x); end
      default: begin drv_a(0, ma, x); drv_b(0, mb, x); end
    endcase
    tag = "R4"; tick();
    case (kind)
      0: drv_b(1, mb, x);
      1: drv_a(1, ma, x);
      3: drv_b(1, mb, x);
      4: drv_a(1, ma, x);
      default: begin drv_a(1, ma, x); drv_b(1, mb, x); end
    endcase
    tag = first; tick();
    // hold the clash with fresh write data
    drv_a(1, ma, x); drv_b(1, mb, x);
    tag = "R8"; tick();
    drv_a(1, ma, x); drv_b(1, mb, x);
    tag = "R9"; tick();
    // winner moves away
    if (kind == 1 || kind == 4) begin drv_b(1, mb, x + 8'd2); drv_a(1, ma, x); end
    else begin drv_a(1, ma, x + 8'd2); drv_b(1, mb, x); end
    tag = "R10"; tick();
    // both read the contended word
    drv_a(1, 0, x); drv_b(1, 0, x);
    tag = "R11"; tick();
    drv_a(0, 0, x); drv_b(0, 0, x);
    tag = "R4"; tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R4";
    chk("A wait in reset", 32'(a_wait_n), 32'd1);
    chk("B wait in reset", 32'(b_wait_n), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: fill the array through port A
    tag = "R2";
    for (int i = 0; i < 256; i++) begin
      drv_a(1, 1, 8'(i)); a_wd = 8'(i * 7 + 3); tick();
    end
    drv_a(0, 0, 0);
    // R3: read back through port B
    tag = "R3";
    for (int i = 0; i < 256; i++) begin
      drv_b(1, 0, 8'(i)); tick();
    end
    // R1: deselected port with strobes low must not write
    tag = "R1";
    drv_b(0, 1, 8'd3); b_we_n = 1'b0; b_oe_n = 1'b0; b_wd = 8'hEE; tick();
    drv_b(0, 0, 0); drv_a(1, 0, 8'd3); tick();
    chk("R1 word 3 untouched", 32'(a_rd), 32'(8'd24));
    // R3: output strobe high is a no-op
    tag = "R3";
    drv_a(1, 0, 8'd9); a_oe_n = 1'b1; tick();
    drv_a(0, 0, 0); tick();
    // contention in every winner order and mode pairing
    for (int k = 0; k < 5; k++)
      for (int ma = 0; ma < 2; ma++)
        for (int mb = 0; mb < 2; mb++)
          contend(k, ma[0], mb[0], 8'(20 + k * 40 + ma * 10 + mb * 4));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule